// File: doc/BRIEF.md
# USB Device Control and Interrupt Registers

This block is the software-visible control and event-flag register set of a full-speed USB device controller, reached from an 8-bit CPU bus through a small address, write strobe and write-data interface with a combinational read path. One control register drives the D+ pull-up enable that connects the device to the bus or disconnects it. It also issues one-shot requests for an upstream resume, and it arms an option that turns the next detected bus reset into a reset of the CPU side only. The USB controller itself stays in its current state.

A second register collects sticky event flags. The USB line-state logic sets them with single-cycle pulses, and firmware acknowledges each flag by writing zero to its bit. A third register holds one enable bit per flag. A registered, glitch-free general interrupt line is raised while any flag and its enable are both set. The resume waveform, the serial engine and clock gating are outside this block.

Top module: `usbdev_ctl_irq`

## Requirements
- R1: Address 0 reads the control register: bit 0 is the detach bit, bit 2 is the reset-CPU bit, and bits 7:3 and bit 1 always read zero. After reset the register reads 0x01.
- R2: `pullup_en` is the inverse of the detach bit. A write of 0 to bit 0 of address 0 sets `pullup_en` to 1 from the cycle after the write.
- R3: A write to address 0 with bit 1 = 1 and bit 0 = 0, while `ctl_en` = 1, produces `wake_pulse` = 1 for exactly one cycle, in the cycle after the write. There is no pulse if bit 1 is written 0, if bit 0 is written 1, or if `ctl_en` = 0. Bit 1 always reads back as 0.
- R4: The reset-CPU bit takes the value of bit 2 of a write to address 0 while `ctl_en` = 1. From the cycle after `ctl_en` is seen at 0, it reads 0 and it ignores writes while `ctl_en` stays 0.
- R5: While the reset-CPU bit is 1 and `ctl_en` = 1, a rising edge on `bus_rst_det` drives `cpu_rst` high for exactly RST_CYCLES cycles, starting the cycle after the edge. Holding `bus_rst_det` high does not start a new pulse, and an edge while the bit is 0 gives no pulse.
- R6: Address 1 reads the flag register: bit 6 upstream-resume-sent, bit 5 end-of-resume, bit 4 wakeup, bit 3 end-of-reset, bit 2 start-of-frame and bit 0 suspend. Bits 7 and 1 read 0, and all flags reset to 0. A 1 on bit k of `ev_pulse` sets flag k from the next cycle. Pulses on bits 7 and 1 are ignored.
- R7: A write to address 1 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged.
- R8: When an event pulse and a clearing write reach the same flag in one cycle, the flag ends up set.
- R9: Address 2 reads the enable register. Its bits sit at the same positions as the flags, bits 7 and 1 read 0, and it resets to 0x00.
- R10: `gen_irq` is 1 in the cycle after any flag and its enable bit are both 1, and 0 in the cycle after no such pair exists.
- R11: Address 3 reads 0x00, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_en | input | 1 | USB controller enabled |
| addr | input | 2 | Register address (0 control, 1 flags, 2 enables) |
| wr | input | 1 | Write strobe for the addressed register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register (combinational) |
| ev_pulse | input | 8 | Single-cycle event pulses, one per flag bit position |
| bus_rst_det | input | 1 | USB bus reset detected (level) |
| pullup_en | output | 1 | D+ pull-up enable |
| wake_pulse | output | 1 | One-cycle upstream-resume request |
| cpu_rst | output | 1 | Reset to the CPU and the non-USB peripherals |
| gen_irq | output | 1 | Combined USB general interrupt |

## Verification
Register writes and event pulses take effect at the first clock edge, so a read back on `rdata` or a look at `pullup_en` is due one cycle later. `wake_pulse` and the start of `cpu_rst` also come one cycle after the write or the detected edge. `gen_irq` adds one more register, so it trails the flag or enable change by two edges. The bench drives inputs and samples outputs on the falling edge. It samples each result at the falling edge that follows the rising edge where that result is due, counts the cycles that `cpu_rst` stays high, and watches on the following cycles that `wake_pulse` and `cpu_rst` do not appear again.

// File: rtl/usbdev_pkg.sv
package usbdev_pkg;
   localparam int unsigned REG_W = 8;
   localparam int unsigned ADR_W = 2;

   localparam logic [ADR_W-1:0] ADR_CTL  = 2'd0;
   localparam logic [ADR_W-1:0] ADR_FLAG = 2'd1;
   localparam logic [ADR_W-1:0] ADR_IEN  = 2'd2;

   localparam int unsigned DET_BIT  = 0;
   localparam int unsigned WAKE_BIT = 1;
   localparam int unsigned RCPU_BIT = 2;

   // implemented flag positions: 6,5,4,3,2,0
   localparam logic [REG_W-1:0] FLAG_MASK_DEF = 8'b0111_1101;
endpackage

// File: rtl/usbdev_ctl_reg.sv
module usbdev_ctl_reg
   import usbdev_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_en,
   input  logic             wr_ctl,
   input  logic [REG_W-1:0] wdata,
   output logic             detach_q,
   output logic             rstcpu_q,
   output logic             wake_pulse
);
   logic wake_req;

   assign wake_req = wr_ctl & ctl_en & wdata[WAKE_BIT] & ~wdata[DET_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         detach_q   <= 1'b1;
         rstcpu_q   <= 1'b0;
         wake_pulse <= 1'b0;
      end else begin
         wake_pulse <= wake_req;
         if (wr_ctl) begin
            detach_q <= wdata[DET_BIT];
         end
         if (!ctl_en) begin
            rstcpu_q <= 1'b0;
         end else if (wr_ctl) begin
            rstcpu_q <= wdata[RCPU_BIT];
         end
      end
   end
endmodule

// File: rtl/usbdev_irq_reg.sv
module usbdev_irq_reg
   import usbdev_pkg::*;
#(
   parameter logic [REG_W-1:0] FLAG_MASK = FLAG_MASK_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_flag,
   input  logic             wr_ien,
   input  logic [REG_W-1:0] wdata,
   input  logic [REG_W-1:0] ev_pulse,
   output logic [REG_W-1:0] flags_q,
   output logic [REG_W-1:0] ien_q,
   output logic             gen_irq
);
   for (genvar k = 0; k < REG_W; k++) begin : g_bit
      if (FLAG_MASK[k]) begin : g_impl
         logic clr;
         assign clr = wr_flag & ~wdata[k];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               flags_q[k] <= 1'b0;
               ien_q[k]   <= 1'b0;
            end else begin
               // a set event beats a clearing write
               flags_q[k] <= ev_pulse[k] | (flags_q[k] & ~clr);
               if (wr_ien) begin
                  ien_q[k] <= wdata[k];
               end
            end
         end
      end else begin : g_rsvd
         assign flags_q[k] = 1'b0;
         assign ien_q[k]   = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gen_irq <= 1'b0;
      end else begin
         gen_irq <= |(flags_q & ien_q);
      end
   end
endmodule

// File: rtl/usbdev_rst_pulse.sv
module usbdev_rst_pulse #(
   parameter int unsigned RST_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic bus_rst_det,
   output logic cpu_rst
);
   localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES);

   logic             det_d;
   logic [CNT_W-1:0] cnt_q;
   logic             trig;

   assign trig    = arm & bus_rst_det & ~det_d;
   assign cpu_rst = (cnt_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         det_d <= 1'b0;
         cnt_q <= '0;
      end else begin
         det_d <= bus_rst_det;
         if (trig) begin
            cnt_q <= CNT_LOAD;
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end
endmodule

// File: rtl/usbdev_ctl_irq.sv
module usbdev_ctl_irq
   import usbdev_pkg::*;
#(
   parameter int unsigned      RST_CYCLES = 16,
   parameter logic [REG_W-1:0] FLAG_MASK  = FLAG_MASK_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_en,
   input  logic [ADR_W-1:0] addr,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   input  logic [REG_W-1:0] ev_pulse,
   input  logic             bus_rst_det,
   output logic             pullup_en,
   output logic             wake_pulse,
   output logic             cpu_rst,
   output logic             gen_irq
);
   if (RST_CYCLES < 1) begin : g_bad_len
      $error("RST_CYCLES must be at least 1");
   end
   if (FLAG_MASK[WAKE_BIT] || FLAG_MASK[REG_W-1]) begin : g_bad_mask
      $error("FLAG_MASK must leave bits 7 and 1 reserved");
   end

   logic             detach_q;
   logic             rstcpu_q;
   logic [REG_W-1:0] flags_q;
   logic [REG_W-1:0] ien_q;
   logic [REG_W-1:0] ctl_rd;

   usbdev_ctl_reg ctl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_en     (ctl_en),
      .wr_ctl     (wr && addr == ADR_CTL),
      .wdata      (wdata),
      .detach_q   (detach_q),
      .rstcpu_q   (rstcpu_q),
      .wake_pulse (wake_pulse)
   );

   usbdev_irq_reg #(.FLAG_MASK(FLAG_MASK)) irq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_flag  (wr && addr == ADR_FLAG),
      .wr_ien   (wr && addr == ADR_IEN),
      .wdata    (wdata),
      .ev_pulse (ev_pulse),
      .flags_q  (flags_q),
      .ien_q    (ien_q),
      .gen_irq  (gen_irq)
   );

   usbdev_rst_pulse #(.RST_CYCLES(RST_CYCLES)) rstp_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .arm         (rstcpu_q & ctl_en),
      .bus_rst_det (bus_rst_det),
      .cpu_rst     (cpu_rst)
   );

   assign pullup_en = ~detach_q;

   always_comb begin
      ctl_rd           = '0;
      ctl_rd[DET_BIT]  = detach_q;
      ctl_rd[RCPU_BIT] = rstcpu_q;
   end

   always_comb begin
      case (addr)
         ADR_CTL:  rdata = ctl_rd;
         ADR_FLAG: rdata = flags_q;
         ADR_IEN:  rdata = ien_q;
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/usbdev_ctl_irq_chk.sv
module usbdev_ctl_irq_chk
   import usbdev_pkg::*;
#(
   parameter logic [REG_W-1:0] FLAG_MASK = FLAG_MASK_DEF
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctl_en,
   input logic [ADR_W-1:0] addr,
   input logic [REG_W-1:0] rdata,
   input logic [REG_W-1:0] ev_pulse,
   input logic [REG_W-1:0] flags_q,
   input logic [REG_W-1:0] ien_q,
   input logic             rstcpu_q,
   input logic             wake_pulse,
   input logic             cpu_rst,
   input logic             gen_irq
);
   assert_ctl_rsvd_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADR_CTL) |-> (rdata[7:3] == '0 && rdata[WAKE_BIT] == 1'b0));

   assert_wake_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);

   assert_wake_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> $past(ctl_en));

   assert_rcpu_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_en |=> !rstcpu_q);

   assert_rst_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_rst) |-> $past(rstcpu_q && ctl_en));

   assert_flag_rsvd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q & ~FLAG_MASK) == '0);

   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((ev_pulse & FLAG_MASK) != '0) |=>
         ((flags_q & $past(ev_pulse & FLAG_MASK)) == $past(ev_pulse & FLAG_MASK)));

   assert_irq_raise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags_q & ien_q) != '0) |=> gen_irq);
endmodule

bind usbdev_ctl_irq usbdev_ctl_irq_chk #(.FLAG_MASK(FLAG_MASK)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .ctl_en     (ctl_en),
   .addr       (addr),
   .rdata      (rdata),
   .ev_pulse   (ev_pulse),
   .flags_q    (flags_q),
   .ien_q      (ien_q),
   .rstcpu_q   (rstcpu_q),
   .wake_pulse (wake_pulse),
   .cpu_rst    (cpu_rst),
   .gen_irq    (gen_irq)
);

// File: tb/usbdev_ctl_irq_tb.sv
module usbdev_ctl_irq_tb_top;
   localparam int unsigned RSTC = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_en = 1'b1;
   logic [1:0] addr = 2'd0;
   logic       wr = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic [7:0] ev_pulse = 8'h00;
   logic       bus_rst_det = 1'b0;
   logic       pullup_en, wake_pulse, cpu_rst, gen_irq;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   usbdev_ctl_irq #(.RST_CYCLES(RSTC)) dut_i (
      .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .addr(addr), .wr(wr),
      .wdata(wdata), .rdata(rdata), .ev_pulse(ev_pulse),
      .bus_rst_det(bus_rst_det), .pullup_en(pullup_en),
      .wake_pulse(wake_pulse), .cpu_rst(cpu_rst), .gen_irq(gen_irq)
   );

   // fields: ev[24:17] wr[16] wdata[15:8] expected flags[7:0]
   localparam logic [24:0] VEC [10] = '{
      {8'h40, 1'b0, 8'h00, 8'h40},
      {8'h21, 1'b0, 8'h00, 8'h61},
      {8'h02, 1'b0, 8'h00, 8'h61},
      {8'h00, 1'b1, 8'hFF, 8'h61},
      {8'h00, 1'b1, 8'hBF, 8'h21},
      {8'h1C, 1'b1, 8'h00, 8'h1C},
      {8'h80, 1'b0, 8'h00, 8'h1C},
      {8'h00, 1'b1, 8'hF7, 8'h14},
      {8'h04, 1'b1, 8'hFB, 8'h14},
      {8'h00, 1'b1, 8'h00, 8'h00}
   };

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd_check(input string tag, input logic [1:0] a, input logic [7:0] exp);
      addr = a;
      #1;
      check(tag, rdata, exp);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      int hi;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      rd_check("R1 ctl reset", 2'd0, 8'h01);
      rd_check("R6 flags reset", 2'd1, 8'h00);
      rd_check("R9 ien reset", 2'd2, 8'h00);
      check("R2 pullup reset", {7'd0, pullup_en}, 8'h00);
      check("R10 irq reset", {7'd0, gen_irq}, 8'h00);
      check("R5 cpu_rst reset", {7'd0, cpu_rst}, 8'h00);

      // flag vector table
      for (int i = 0; i < 10; i++) begin
         ev_pulse = VEC[i][24:17];
         addr = 2'd1; wdata = VEC[i][15:8]; wr = VEC[i][16];
         @(negedge clk);
         ev_pulse = 8'h00; wr = 1'b0;
         rd_check($sformatf("R6/R7/R8 vector %0d", i), 2'd1, VEC[i][7:0]);
      end

      // unused address
      wr_reg(2'd3, 8'hFF);
      rd_check("R11 addr3 read", 2'd3, 8'h00);
      rd_check("R11 ctl unchanged", 2'd0, 8'h01);
      rd_check("R11 ien unchanged", 2'd2, 8'h00);

      // attach
      wr_reg(2'd0, 8'h00);
      rd_check("R2 ctl attached", 2'd0, 8'h00);
      check("R2 pullup on", {7'd0, pullup_en}, 8'h01);

      // remote wakeup
      wr_reg(2'd0, 8'h02);
      check("R3 wake pulse", {7'd0, wake_pulse}, 8'h01);
      rd_check("R3 bit1 reads 0", 2'd0, 8'h00);
      @(negedge clk);
      check("R3 wake single", {7'd0, wake_pulse}, 8'h00);
      wr_reg(2'd0, 8'h03);
      check("R3 no wake when detaching", {7'd0, wake_pulse}, 8'h00);
      check("R2 pullup off", {7'd0, pullup_en}, 8'h00);
      wr_reg(2'd0, 8'h00);
      check("R3 no wake for zero", {7'd0, wake_pulse}, 8'h00);
      ctl_en = 1'b0;
      wr_reg(2'd0, 8'h02);
      check("R3 no wake when disabled", {7'd0, wake_pulse}, 8'h00);
      ctl_en = 1'b1;

      // reset-CPU bit
      wr_reg(2'd0, 8'h04);
      rd_check("R4 rcpu set", 2'd0, 8'h04);
      wr_reg(2'd0, 8'h00);
      rd_check("R4 rcpu cleared by write", 2'd0, 8'h00);
      wr_reg(2'd0, 8'h04);
      ctl_en = 1'b0;
      @(negedge clk);
      rd_check("R4 rcpu cleared by disable", 2'd0, 8'h00);
      wr_reg(2'd0, 8'h04);
      rd_check("R4 rcpu write ignored disabled", 2'd0, 8'h00);
      ctl_en = 1'b1;

      // bus reset without arm
      bus_rst_det = 1'b1;
      hi = 0;
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         if (cpu_rst) hi++;
      end
      bus_rst_det = 1'b0;
      check("R5 no pulse unarmed", 8'(hi), 8'd0);
      wr_reg(2'd0, 8'h04);
      bus_rst_det = 1'b1;
      @(negedge clk);
      check("R5 pulse starts", {7'd0, cpu_rst}, 8'h01);
      hi = 1;
      for (int c = 0; c < RSTC + 4; c++) begin
         @(negedge clk);
         if (cpu_rst) hi++;
      end
      check("R5 pulse length, no retrigger", 8'(hi), 8'(RSTC));
      bus_rst_det = 1'b0;

      // enables and interrupt
      wr_reg(2'd2, 8'hFF);
      rd_check("R9 ien mask", 2'd2, 8'h7D);
      wr_reg(2'd2, 8'h40);
      ev_pulse = 8'h01;
      @(negedge clk);
      ev_pulse = 8'h00;
      @(negedge clk);
      check("R10 no irq unmatched", {7'd0, gen_irq}, 8'h00);
      wr_reg(2'd2, 8'h01);
      check("R10 irq not yet", {7'd0, gen_irq}, 8'h00);
      @(negedge clk);
      check("R10 irq raised", {7'd0, gen_irq}, 8'h01);
      wr_reg(2'd1, 8'hFE);
      check("R10 irq one more cycle", {7'd0, gen_irq}, 8'h01);
      @(negedge clk);
      check("R10 irq dropped", {7'd0, gen_irq}, 8'h00);

      done = 1'b1;
      finish_run();
   end
endmodule